// File: doc/BRIEF.md
# Chained DMA Descriptor Loader

This block refills the register set of one DMA channel from a chain of descriptors in memory. When the channel reports that its current transfer has finished, the loader looks at the channel's next-descriptor pointer. If the address part of that pointer is zero, the chain has ended and the loader reports completion. If it is not zero, the loader reads a five-word descriptor through a simple single-outstanding read port. The words are, in order: source address, destination address, next pointer, control word and transfer count. Once all five words have arrived, the loader writes them into the channel registers in one cycle and tells the channel to continue.

Software can also write any of the five registers directly, both to start a chain and to redirect it. A write to the next pointer between loads takes effect at the next completion. The next pointer addresses word-aligned descriptors through its upper 30 bits. Its bit 0 picks which of two bus masters performs the fetch. A chain whose last descriptor points back to its first forms a ring, and the loader follows it without end. An error response on any word abandons the load, leaves the registers as they were and raises an error pulse.

Top module: `dl_desc_loader`

## Requirements
- R1: After reset, all five channel registers read zero, and `busy`, `rd_req`, `chan_go`, `chain_end` and `load_err` are low.
- R2: A software write with `sw_we` high loads `sw_wdata` into the register chosen by `sw_sel`: 0 source, 1 destination, 2 next pointer, 3 control, 4 count. Codes 5 to 7 change no register.
- R3: `xfer_done` while idle, with `next_ptr[31:2]` nonzero, starts a fetch. The fetch makes exactly five reads, at base, base+4, base+8, base+12 and base+16 in that order, with one read outstanding at a time.
- R4: The fetched words go to source, destination, next pointer, control and count respectively. All five registers change together, and `chan_go` pulses for one cycle in the cycle after the fifth response is accepted.
- R5: The fetch base is `next_ptr` with bits 1:0 cleared. `rd_master` equals `next_ptr[0]` as it was when the fetch started, and stays at that value for the whole fetch.
- R6: Once raised, `rd_req` stays high with `rd_addr` and `rd_master` unchanged until a cycle in which `rd_ready` is high.
- R7: `xfer_done` while idle with `next_ptr[31:2]` zero issues no read and pulses `chain_end` in the next cycle.
- R8: A ring of descriptors is followed indefinitely. A descriptor whose next pointer returns to an earlier descriptor is fetched again in the same way.
- R9: A response with `rd_err` high during a fetch ends the load. `load_err` pulses in the next cycle, no further read is made, `chan_go` does not pulse and all five registers keep their previous values.
- R10: `xfer_done` while a fetch is in progress is ignored. It starts no second fetch.
- R11: A software write to the next pointer made between loads sets the address and master of the next fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_we | input | 1 | Software register write strobe |
| sw_sel | input | 3 | Register select for the software write |
| sw_wdata | input | 32 | Software write data |
| xfer_done | input | 1 | Current transfer of the channel has finished |
| rd_req | output | 1 | Read request valid |
| rd_addr | output | 32 | Read word address |
| rd_master | output | 1 | Bus master chosen for this read |
| rd_ready | input | 1 | Read request accepted |
| rd_valid | input | 1 | Read response valid |
| rd_data | input | 32 | Read response data |
| rd_err | input | 1 | Read response carries an error |
| src_addr | output | 32 | Channel source address register |
| dst_addr | output | 32 | Channel destination address register |
| next_ptr | output | 32 | Next-descriptor pointer register |
| ctrl_word | output | 32 | Channel control register |
| count_word | output | 32 | Transfer count register, in transfer units |
| busy | output | 1 | A descriptor fetch is in progress |
| chan_go | output | 1 | Pulse: new descriptor loaded, channel may continue |
| chain_end | output | 1 | Pulse: chain finished with no further descriptor |
| load_err | output | 1 | Pulse: fetch aborted by an error response |

## Verification
The bench uses the default five-word descriptor and 32-bit widths, with a memory of seven descriptors linked into a ring. It sweeps every combination of request-accept delay 0 to 2 and response delay 1 to 3 while walking the ring, so loads wrap back to the first descriptor. It injects an error at each of the five word positions in turn. It also covers a zero-address pointer, unaligned pointer bits, both master selections and a redirect by software.

// File: rtl/dl_pkg.sv
package dl_pkg;
  localparam int ADDR_W     = 32;
  localparam int DATA_W     = 32;
  localparam int DESC_WORDS = 5;
  localparam int IDX_W      = $clog2(DESC_WORDS);
  localparam int SEL_W      = 3;

  // register slot numbers; the fetch order matches these slots
  localparam int SLOT_SRC   = 0;
  localparam int SLOT_DST   = 1;
  localparam int SLOT_NEXT  = 2;
  localparam int SLOT_CTRL  = 3;
  localparam int SLOT_COUNT = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} ld_state_t;

  function automatic logic [ADDR_W-1:0] desc_base(input logic [ADDR_W-1:0] p);
    return {p[ADDR_W-1:2], 2'b00};
  endfunction

  function automatic logic desc_is_last(input logic [ADDR_W-1:0] p);
    return p[ADDR_W-1:2] == '0;
  endfunction

  function automatic logic [ADDR_W-1:0] word_addr(input logic [ADDR_W-1:0] b,
                                                  input logic [IDX_W-1:0] i);
    return b + ADDR_W'({i, 2'b00});
  endfunction
endpackage

// File: rtl/dl_desc_regs.sv
module dl_desc_regs
  import dl_pkg::*;
(
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                sw_we,
  input  logic [SEL_W-1:0]                    sw_sel,
  input  logic [DATA_W-1:0]                   sw_wdata,
  input  logic                                load_en,
  input  logic [DESC_WORDS-1:0][DATA_W-1:0]   load_words,
  output logic [DESC_WORDS-1:0][DATA_W-1:0]   regs_q
);
  for (genvar i = 0; i < DESC_WORDS; i++) begin : g_slot
    wire sw_hit = sw_we && (sw_sel == SEL_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)       regs_q[i] <= '0;
      else if (load_en) regs_q[i] <= load_words[i];
      else if (sw_hit)  regs_q[i] <= sw_wdata;
    end
  end
endmodule

// File: rtl/dl_fetch_seq.sv
module dl_fetch_seq
  import dl_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start_req,
  input  logic [ADDR_W-1:0]                 ptr,
  input  logic                              rd_ready,
  input  logic                              rd_valid,
  input  logic [DATA_W-1:0]                 rd_data,
  input  logic                              rd_err,
  output logic                              rd_req,
  output logic [ADDR_W-1:0]                 rd_addr,
  output logic                              rd_master,
  output logic                              busy,
  output logic [DESC_WORDS-1:0][DATA_W-1:0] fetched,
  output logic                              commit_en,
  output logic                              chan_go,
  output logic                              chain_end,
  output logic                              load_err
);
  ld_state_t                              state;
  logic [IDX_W-1:0]                       idx;
  logic [ADDR_W-1:0]                      base;
  logic                                   master;
  logic [DESC_WORDS-2:0][DATA_W-1:0]      held;

  wire idle      = (state == ST_IDLE);
  wire take      = start_req && idle;
  wire ptr_last  = desc_is_last(ptr);
  wire resp_ok   = (state == ST_WAIT) && rd_valid && !rd_err;
  wire resp_bad  = (state == ST_WAIT) && rd_valid && rd_err;

  assign commit_en = resp_ok && (idx == IDX_W'(DESC_WORDS-1));
  assign rd_req    = (state == ST_REQ);
  assign rd_addr   = word_addr(base, idx);
  assign rd_master = master;
  assign busy      = !idle;

  for (genvar i = 0; i < DESC_WORDS-1; i++) begin : g_hold
    always_ff @(posedge clk) begin
      if (!rst_n)                             held[i] <= '0;
      else if (resp_ok && idx == IDX_W'(i))   held[i] <= rd_data;
    end
    assign fetched[i] = held[i];
  end
  assign fetched[DESC_WORDS-1] = rd_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      idx       <= '0;
      base      <= '0;
      master    <= 1'b0;
      chan_go   <= 1'b0;
      chain_end <= 1'b0;
      load_err  <= 1'b0;
    end else begin
      chan_go   <= commit_en;
      chain_end <= take && ptr_last;
      load_err  <= resp_bad;
      case (state)
        ST_IDLE: if (take && !ptr_last) begin
          base   <= desc_base(ptr);
          master <= ptr[0];
          idx    <= '0;
          state  <= ST_REQ;
        end
        ST_REQ: if (rd_ready) state <= ST_WAIT;
        ST_WAIT: begin
          if (resp_bad)       state <= ST_IDLE;
          else if (commit_en) state <= ST_IDLE;
          else if (resp_ok) begin
            idx   <= idx + 1'b1;
            state <= ST_REQ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dl_desc_loader.sv
module dl_desc_loader
  import dl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we,
  input  logic [2:0]        sw_sel,
  input  logic [31:0]       sw_wdata,
  input  logic              xfer_done,
  output logic              rd_req,
  output logic [31:0]       rd_addr,
  output logic              rd_master,
  input  logic              rd_ready,
  input  logic              rd_valid,
  input  logic [31:0]       rd_data,
  input  logic              rd_err,
  output logic [31:0]       src_addr,
  output logic [31:0]       dst_addr,
  output logic [31:0]       next_ptr,
  output logic [31:0]       ctrl_word,
  output logic [31:0]       count_word,
  output logic              busy,
  output logic              chan_go,
  output logic              chain_end,
  output logic              load_err
);
  logic [DESC_WORDS-1:0][DATA_W-1:0] fetched;
  logic [DESC_WORDS-1:0][DATA_W-1:0] regs_q;
  logic                              commit_en;

  dl_fetch_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (xfer_done),
    .ptr       (regs_q[SLOT_NEXT]),
    .rd_ready  (rd_ready),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .rd_err    (rd_err),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .rd_master (rd_master),
    .busy      (busy),
    .fetched   (fetched),
    .commit_en (commit_en),
    .chan_go   (chan_go),
    .chain_end (chain_end),
    .load_err  (load_err)
  );

  dl_desc_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_we      (sw_we),
    .sw_sel     (sw_sel),
    .sw_wdata   (sw_wdata),
    .load_en    (commit_en),
    .load_words (fetched),
    .regs_q     (regs_q)
  );

  assign src_addr   = regs_q[SLOT_SRC];
  assign dst_addr   = regs_q[SLOT_DST];
  assign next_ptr   = regs_q[SLOT_NEXT];
  assign ctrl_word  = regs_q[SLOT_CTRL];
  assign count_word = regs_q[SLOT_COUNT];
endmodule

// File: rtl/dl_loader_chk.sv
module dl_loader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        xfer_done,
  input logic        busy,
  input logic [31:0] next_ptr,
  input logic        rd_req,
  input logic        rd_ready,
  input logic [31:0] rd_addr,
  input logic        rd_master,
  input logic        rd_valid,
  input logic        rd_err,
  input logic        commit_en,
  input logic        chan_go,
  input logic        chain_end,
  input logic        load_err
);
  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ready |=> rd_req && $stable(rd_addr) && $stable(rd_master));

  assert_addr_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> rd_addr[1:0] == 2'b00);

  assert_zero_ptr_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done && !busy && next_ptr[31:2] == 30'd0 |=> chain_end && !rd_req);

  assert_error_aborts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !rd_req && rd_valid && rd_err |=> load_err && !chan_go && !busy);

  assert_commit_go_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en |=> chan_go && !busy);

  assert_single_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({chan_go, chain_end, load_err}));

  assert_busy_ignores_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !commit_en && !(rd_valid && rd_err) |=> busy);
endmodule

bind dl_desc_loader dl_loader_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .xfer_done (xfer_done),
  .busy      (busy),
  .next_ptr  (next_ptr),
  .rd_req    (rd_req),
  .rd_ready  (rd_ready),
  .rd_addr   (rd_addr),
  .rd_master (rd_master),
  .rd_valid  (rd_valid),
  .rd_err    (rd_err),
  .commit_en (commit_en),
  .chan_go   (chan_go),
  .chain_end (chain_end),
  .load_err  (load_err)
);

// File: tb/dl_desc_loader_test.sv
`timescale 1ns/1ps
module dl_desc_loader_test;
  logic clk = 0, rst_n = 0;
  logic sw_we = 0; logic [2:0] sw_sel = 0; logic [31:0] sw_wdata = 0;
  logic xfer_done = 0;
  logic rd_req, rd_master, rd_ready = 0, rd_valid = 0, rd_err = 0;
  logic [31:0] rd_addr, rd_data = 0;
  logic [31:0] src_addr, dst_addr, next_ptr, ctrl_word, count_word;
  logic busy, chan_go, chain_end, load_err;

  always #5 clk = ~clk;

  dl_desc_loader uut (.*);

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;
  logic [31:0] nextp [0:7];
  int ready_lat = 0, resp_lat = 1;
  logic [31:0] err_addr = 32'h1;
  logic [31:0] alog [0:15];
  logic        mlog [0:15];
  int acc_n = 0;
  int go_n = 0, end_n = 0, err_n = 0;

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    if (a[4:2] == 3'd2) return nextp[a[7:5]];
    return (a * 32'h0001_9E37) ^ 32'h5A5A_0000 ^ {29'd0, a[4:2]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder
  initial begin
    bit pend = 0; int pcnt = 0, rcnt = 0; logic [31:0] pa = 0;
    forever begin
      @(negedge clk);
      if (rd_valid) begin rd_valid = 0; rd_err = 0; end
      if (rd_ready) begin
        rd_ready = 0; pend = 1; pcnt = resp_lat;
      end
      if (pend) begin
        if (pcnt <= 1) begin
          rd_valid = 1; rd_data = mem_rd(pa); rd_err = (pa == err_addr); pend = 0;
        end else pcnt--;
      end else if (rd_req && !rd_ready) begin
        if (rcnt >= ready_lat) begin
          rd_ready = 1; pa = rd_addr;
          if (acc_n < 16) begin alog[acc_n] = rd_addr; mlog[acc_n] = rd_master; end
          acc_n++; rcnt = 0;
        end else rcnt++;
      end
    end
  end

  task automatic sw_write(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk); sw_we = 1; sw_sel = s; sw_wdata = d;
    @(negedge clk); sw_we = 0;
  endtask

  // pulse xfer_done for 'hold' cycles, wait for one event; returns cycles waited
  task automatic do_load(input int hold, output int lat);
    int g0 = go_n, e0 = end_n, r0 = err_n;
    acc_n = 0; lat = 0;
    @(negedge clk); xfer_done = 1;
    for (int c = 1; c < 300; c++) begin
      @(negedge clk);
      if (c >= hold) xfer_done = 0;
      if (chan_go) go_n++;
      if (chain_end) end_n++;
      if (load_err) err_n++;
      if (go_n != g0 || end_n != e0 || err_n != r0) begin lat = c; break; end
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    summary();
  end

  initial begin
    int lat, g0;
    logic [31:0] b, snap [0:4];
    logic m;
    for (int k = 0; k < 8; k++) nextp[k] = (32'((k % 7) + 1) << 5) | 32'(k & 1);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(src_addr == 0 && dst_addr == 0 && next_ptr == 0 && ctrl_word == 0 && count_word == 0,
        "R1 regs zero", src_addr | dst_addr | next_ptr | ctrl_word | count_word, 0);
    chk(!busy && !rd_req && !chan_go && !chain_end && !load_err, "R1 outputs low",
        {27'd0, busy, rd_req, chan_go, chain_end, load_err}, 0);

    // R2 software writes
    for (int s = 0; s < 5; s++) sw_write(3'(s), 32'hC000_0000 + 32'(s));
    chk(src_addr == 32'hC000_0000, "R2 src", src_addr, 32'hC000_0000);
    chk(dst_addr == 32'hC000_0001, "R2 dst", dst_addr, 32'hC000_0001);
    chk(next_ptr == 32'hC000_0002, "R2 next", next_ptr, 32'hC000_0002);
    chk(ctrl_word == 32'hC000_0003, "R2 ctrl", ctrl_word, 32'hC000_0003);
    chk(count_word == 32'hC000_0004, "R2 count", count_word, 32'hC000_0004);
    for (int s = 5; s < 8; s++) sw_write(3'(s), 32'hDEAD_BEEF);
    chk(src_addr == 32'hC000_0000 && dst_addr == 32'hC000_0001 && next_ptr == 32'hC000_0002 &&
        ctrl_word == 32'hC000_0003 && count_word == 32'hC000_0004, "R2 unused codes ignored",
        src_addr ^ dst_addr ^ next_ptr ^ ctrl_word ^ count_word, 32'hC000_0004);

    // sweep over latencies while walking the ring (R3 R4 R5 R8 R10)
    sw_write(3'd2, 32'h20);
    for (int i = 0; i < 9; i++) begin
      ready_lat = i / 3; resp_lat = (i % 3) + 1;
      b = {next_ptr[31:2], 2'b00}; m = next_ptr[0];
      g0 = go_n;
      do_load(i == 0 ? 3 : 1, lat);
      chk(go_n == g0 + 1, "R4 go pulse", 32'(go_n - g0), 1);
      chk(acc_n == 5, (i == 0) ? "R10 single fetch while busy" : "R3 five reads", 32'(acc_n), 5);
      for (int j = 0; j < 5; j++) begin
        chk(alog[j] == b + 32'(4 * j), "R3 read order", alog[j], b + 32'(4 * j));
        chk(mlog[j] == m, "R5 master select", {31'd0, mlog[j]}, {31'd0, m});
      end
      chk(src_addr == mem_rd(b), "R4 src loaded", src_addr, mem_rd(b));
      chk(dst_addr == mem_rd(b + 4), "R4 dst loaded", dst_addr, mem_rd(b + 4));
      chk(next_ptr == nextp[b[7:5]], "R4 next loaded", next_ptr, nextp[b[7:5]]);
      chk(ctrl_word == mem_rd(b + 12), "R4 ctrl loaded", ctrl_word, mem_rd(b + 12));
      chk(count_word == mem_rd(b + 16), "R4 count loaded", count_word, mem_rd(b + 16));
      if (i == 7) chk(b == 32'h20, "R8 ring wraps to first", b, 32'h20);
    end

    // R9 error at each word position
    ready_lat = 1; resp_lat = 2;
    for (int j = 0; j < 5; j++) begin
      b = {next_ptr[31:2], 2'b00};
      snap[0] = src_addr; snap[1] = dst_addr; snap[2] = next_ptr; snap[3] = ctrl_word; snap[4] = count_word;
      err_addr = b + 32'(4 * j);
      g0 = go_n;
      do_load(1, lat);
      chk(err_n > 0 && go_n == g0, "R9 error pulse no go", 32'(go_n - g0), 0);
      chk(acc_n == j + 1, "R9 reads stop at error", 32'(acc_n), 32'(j + 1));
      chk(src_addr == snap[0] && dst_addr == snap[1] && next_ptr == snap[2] &&
          ctrl_word == snap[3] && count_word == snap[4], "R9 registers kept",
          src_addr ^ count_word, snap[0] ^ snap[4]);
      chk(!busy, "R9 back to idle", {31'd0, busy}, 0);
    end
    err_addr = 32'h1;

    // R11 software redirect of next pointer
    sw_write(3'd2, 32'h61);
    do_load(1, lat);
    chk(alog[0] == 32'h60 && mlog[0] == 1'b1, "R11 redirect used", alog[0], 32'h60);
    chk(src_addr == mem_rd(32'h60), "R11 redirect loaded", src_addr, mem_rd(32'h60));

    // R5 low bits ignored for address
    sw_write(3'd2, 32'hA3);
    do_load(1, lat);
    chk(alog[0] == 32'hA0, "R5 base clears low bits", alog[0], 32'hA0);
    chk(mlog[0] == 1'b1, "R5 master from bit0", {31'd0, mlog[0]}, 1);

    // R7 zero address field ends chain
    sw_write(3'd2, 32'h3);
    g0 = end_n;
    do_load(1, lat);
    chk(end_n == g0 + 1 && lat == 1, "R7 chain end next cycle", 32'(lat), 1);
    chk(acc_n == 0, "R7 no read", 32'(acc_n), 0);

    summary();
  end
endmodule